// File: doc/BRIEF.md
# Accumulator ALU with status flags

This unit is the execute stage of an 8-bit accumulator machine. Each accepted operation combines a register operand, or an 8-bit literal, with the working register W and the carry flag. It then routes the 8-bit result either into W or back toward the register file, and it updates the Carry, Digit Carry and Zero flags only where that operation calls for it. Decoding, memory and the register file sit outside the unit. The surrounding logic presents the operand, the literal, the bit index, the operation code and the destination bit, and it writes the register file whenever `wr_f` is high.

W, the three flags, the register-bound result and the last bit-test outcome are held in registers. A small two-state controller tracks the write-back. It sits in `ST_IDLE` until an accepted operation targets the register operand, then moves to `ST_WRITE`. In `ST_WRITE` it raises `wr_f`. It stays in `ST_WRITE` while further register-targeting operations arrive back to back, and it returns to `ST_IDLE` on any other cycle.

Top module: `acc_alu`

## Requirements
- R1: An operation is taken on a rising clock edge where `op_valid` is 1, and its results appear after that edge. While `op_valid` is 0, W and the flags hold and `wr_f` is 0. The operation codes are: 0 NOP, 1 ADDWF, 2 SUBWF, 3 ANDWF, 4 IORWF, 5 XORWF, 6 COMF, 7 INCF, 8 DECF, 9 MOVF, 10 CLRF, 11 CLRW, 12 MOVWF, 13 RLF, 14 RRF, 15 SWAPF, 16 BCF, 17 BSF, 18 BTST, 19 ADDLW, 20 SUBLW, 21 ANDLW, 22 IORLW, 23 XORLW, 24 MOVLW.
- R2: For codes 1 to 9 and 13 to 15, `dest`=1 sends the result to `res_out` and raises `wr_f` for one cycle, and `dest`=0 loads the result into W with `wr_f` low. Codes 10, 12, 16 and 17 always target the register. Code 11 and codes 19 to 24 always target W. Codes 0 and 18 target neither.
- R3: ADDWF and ADDLW produce the operand plus W modulo 256. C is the carry out of bit 7 and DC is the carry out of bit 3.
- R4: SUBWF produces register minus W and SUBLW produces literal minus W. C=1 means no borrow out of the byte, and DC=1 means no borrow out of the low nibble.
- R5: The logic operations (AND, OR, XOR in both forms), COMF, INCF, DECF, MOVF (with either `dest`), CLRF and CLRW set Z exactly when the result is 0x00 and leave C and DC unchanged.
- R6: INCF wraps 0xFF to 0x00 and DECF wraps 0x00 to 0xFF.
- R7: RLF shifts left with the old C entering bit 0 and bit 7 becoming the new C. RRF shifts right with the old C entering bit 7 and bit 0 becoming the new C. Neither changes DC or Z.
- R8: SWAPF exchanges the two nibbles of the register operand and changes no flag.
- R9: MOVWF, BCF, BSF, MOVLW, NOP and BTST change no flag. MOVWF places W on `res_out`.
- R10: BSF sets and BCF clears the operand bit chosen by `bit_sel` (0 to 7). BTST places that bit on `bit_out`, writes nothing and leaves W unchanged.
- R11: While `rst_n` is 0, W, C, DC, Z, `res_out`, `bit_out` and `wr_f` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation code (see R1) |
| dest | input | 1 | Destination: 1 register, 0 W |
| f_in | input | 8 | Register operand |
| lit_in | input | 8 | Literal operand |
| bit_sel | input | 3 | Bit index for BSF, BCF, BTST |
| res_out | output | 8 | Result bound for the register file |
| wr_f | output | 1 | Register write-back strobe |
| w_out | output | 8 | Working register W |
| c_flag | output | 1 | Carry flag |
| dc_flag | output | 1 | Digit carry flag |
| z_flag | output | 1 | Zero flag |
| bit_out | output | 1 | Last bit-test outcome |

## Verification
Every result of this unit is due exactly one rising edge after the cycle in which `op_valid` was high. W, the flags, `res_out` and `bit_out` then hold until the next accepted operation. `wr_f` is high only for the one cycle after a register-targeting operation. The bench drives inputs on falling edges, drops `op_valid` at the next falling edge, and samples at that same falling edge, half a cycle after the results land. It samples `wr_f` again one cycle later to confirm the pulse has ended. Flags that an operation must leave alone are preset through earlier operations to known values, so that a wrong update shows at the outputs.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 5'd0,
        OP_ADDWF = 5'd1,
        OP_SUBWF = 5'd2,
        OP_ANDWF = 5'd3,
        OP_IORWF = 5'd4,
        OP_XORWF = 5'd5,
        OP_COMF  = 5'd6,
        OP_INCF  = 5'd7,
        OP_DECF  = 5'd8,
        OP_MOVF  = 5'd9,
        OP_CLRF  = 5'd10,
        OP_CLRW  = 5'd11,
        OP_MOVWF = 5'd12,
        OP_RLF   = 5'd13,
        OP_RRF   = 5'd14,
        OP_SWAPF = 5'd15,
        OP_BCF   = 5'd16,
        OP_BSF   = 5'd17,
        OP_BTST  = 5'd18,
        OP_ADDLW = 5'd19,
        OP_SUBLW = 5'd20,
        OP_ANDLW = 5'd21,
        OP_IORLW = 5'd22,
        OP_XORLW = 5'd23,
        OP_MOVLW = 5'd24
    } alu_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } wb_state_e;

endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int NIB_W = DATA_W / 2,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  alu_op_e            op,
    input  logic [DATA_W-1:0]  f_val,
    input  logic [DATA_W-1:0]  lit_val,
    input  logic [DATA_W-1:0]  w_val,
    input  logic               c_in,
    input  logic [IDX_W-1:0]   bit_sel,
    output logic [DATA_W-1:0]  result,
    output logic               c_new,
    output logic               dc_new,
    output logic               upd_c,
    output logic               upd_dc,
    output logic               upd_z,
    output logic               bit_val
);

    logic [DATA_W-1:0] bit_mask;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] addend;
    logic [DATA_W:0]   sum_full;
    logic [NIB_W:0]    nib_full;
    logic              is_lit;
    logic              is_sub;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
        assign bit_mask[gi] = (bit_sel == IDX_W'(gi));
    end

    assign bit_val = |(f_val & bit_mask);

    always_comb begin
        is_lit   = (op == OP_ADDLW) || (op == OP_SUBLW) || (op == OP_ANDLW) ||
                   (op == OP_IORLW) || (op == OP_XORLW) || (op == OP_MOVLW);
        is_sub   = (op == OP_SUBWF) || (op == OP_SUBLW);
        operand  = is_lit ? lit_val : f_val;
        addend   = is_sub ? ~w_val : w_val;
        sum_full = {1'b0, operand} + {1'b0, addend} + (DATA_W+1)'(is_sub);
        nib_full = {1'b0, operand[NIB_W-1:0]} + {1'b0, addend[NIB_W-1:0]}
                   + (NIB_W+1)'(is_sub);
    end

    always_comb begin
        result = '0;
        c_new  = c_in;
        dc_new = nib_full[NIB_W];
        upd_c  = 1'b0;
        upd_dc = 1'b0;
        upd_z  = 1'b0;
        unique case (op)
            OP_ADDWF, OP_SUBWF, OP_ADDLW, OP_SUBLW: begin
                result = sum_full[DATA_W-1:0];
                c_new  = sum_full[DATA_W];
                upd_c  = 1'b1;
                upd_dc = 1'b1;
                upd_z  = 1'b1;
            end
            OP_ANDWF, OP_ANDLW: begin
                result = operand & w_val;
                upd_z  = 1'b1;
            end
            OP_IORWF, OP_IORLW: begin
                result = operand | w_val;
                upd_z  = 1'b1;
            end
            OP_XORWF, OP_XORLW: begin
                result = operand ^ w_val;
                upd_z  = 1'b1;
            end
            OP_COMF: begin
                result = ~f_val;
                upd_z  = 1'b1;
            end
            OP_INCF: begin
                result = f_val + DATA_W'(1);
                upd_z  = 1'b1;
            end
            OP_DECF: begin
                result = f_val - DATA_W'(1);
                upd_z  = 1'b1;
            end
            OP_MOVF: begin
                result = f_val;
                upd_z  = 1'b1;
            end
            OP_CLRF, OP_CLRW: begin
                result = '0;
                upd_z  = 1'b1;
            end
            OP_MOVWF: result = w_val;
            OP_RLF: begin
                result = {f_val[DATA_W-2:0], c_in};
                c_new  = f_val[DATA_W-1];
                upd_c  = 1'b1;
            end
            OP_RRF: begin
                result = {c_in, f_val[DATA_W-1:1]};
                c_new  = f_val[0];
                upd_c  = 1'b1;
            end
            OP_SWAPF: result = {f_val[NIB_W-1:0], f_val[DATA_W-1:NIB_W]};
            OP_BCF:   result = f_val & ~bit_mask;
            OP_BSF:   result = f_val | bit_mask;
            OP_MOVLW: result = lit_val;
            OP_NOP, OP_BTST: result = '0;
            default:  result = '0;
        endcase
    end

endmodule

// File: rtl/wb_ctrl.sv
module wb_ctrl
    import alu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    op_valid,
    input  alu_op_e op,
    input  logic    dest,
    output logic    load_w,
    output logic    load_f,
    output logic    wr_f
);

    wb_state_e state_q;
    wb_state_e state_d;

    always_comb begin
        load_w = 1'b0;
        load_f = 1'b0;
        unique case (op)
            OP_ADDWF, OP_SUBWF, OP_ANDWF, OP_IORWF, OP_XORWF, OP_COMF,
            OP_INCF, OP_DECF, OP_MOVF, OP_RLF, OP_RRF, OP_SWAPF: begin
                load_f = op_valid & dest;
                load_w = op_valid & ~dest;
            end
            OP_CLRF, OP_MOVWF, OP_BCF, OP_BSF: load_f = op_valid;
            OP_CLRW, OP_ADDLW, OP_SUBLW, OP_ANDLW, OP_IORLW, OP_XORLW,
            OP_MOVLW: load_w = op_valid;
            OP_NOP, OP_BTST: begin
                load_w = 1'b0;
                load_f = 1'b0;
            end
            default: begin
                load_w = 1'b0;
                load_f = 1'b0;
            end
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load_f) state_d = ST_WRITE;
            ST_WRITE: if (!load_f) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_f = (state_q == ST_WRITE);
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import alu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic              dest,
    input  logic [DATA_W-1:0] f_in,
    input  logic [DATA_W-1:0] lit_in,
    input  logic [IDX_W-1:0]  bit_sel,
    output logic [DATA_W-1:0] res_out,
    output logic              wr_f,
    output logic [DATA_W-1:0] w_out,
    output logic              c_flag,
    output logic              dc_flag,
    output logic              z_flag,
    output logic              bit_out
);

    alu_op_e           op;
    logic [DATA_W-1:0] result;
    logic              c_new, dc_new, upd_c, upd_dc, upd_z, bit_val;
    logic              load_w, load_f;

    assign op = alu_op_e'(op_code);

    alu_core #(.DATA_W(DATA_W)) u_core (
        .op      (op),
        .f_val   (f_in),
        .lit_val (lit_in),
        .w_val   (w_out),
        .c_in    (c_flag),
        .bit_sel (bit_sel),
        .result  (result),
        .c_new   (c_new),
        .dc_new  (dc_new),
        .upd_c   (upd_c),
        .upd_dc  (upd_dc),
        .upd_z   (upd_z),
        .bit_val (bit_val)
    );

    wb_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op       (op),
        .dest     (dest),
        .load_w   (load_w),
        .load_f   (load_f),
        .wr_f     (wr_f)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_out   <= '0;
            res_out <= '0;
            c_flag  <= 1'b0;
            dc_flag <= 1'b0;
            z_flag  <= 1'b0;
            bit_out <= 1'b0;
        end else if (op_valid) begin
            if (upd_c)  c_flag  <= c_new;
            if (upd_dc) dc_flag <= dc_new;
            if (upd_z)  z_flag  <= (result == '0);
            if (load_w) w_out   <= result;
            if (load_f) res_out <= result;
            if (op == OP_BTST) bit_out <= bit_val;
        end
    end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import alu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [OP_W-1:0]   op_code,
    input logic              dest,
    input logic [DATA_W-1:0] f_in,
    input logic [DATA_W-1:0] lit_in,
    input logic [IDX_W-1:0]  bit_sel,
    input logic [DATA_W-1:0] res_out,
    input logic              wr_f,
    input logic [DATA_W-1:0] w_out,
    input logic              c_flag,
    input logic              dc_flag,
    input logic              z_flag,
    input logic              bit_out
);

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(w_out) && $stable({c_flag, dc_flag, z_flag}) && !wr_f)); // R1

    AST_WRF_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_f |-> $past(op_valid)); // R2

    AST_CLRF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CLRF) |=> (z_flag && wr_f && res_out == '0)); // R5

    AST_LOGIC_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_ANDWF || op_code == OP_IORWF || op_code == OP_XORWF))
        |=> $stable({c_flag, dc_flag})); // R5

    AST_ROT_ONLY_C: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_RLF || op_code == OP_RRF)) |=> $stable({dc_flag, z_flag})); // R7

    AST_SWAP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_SWAPF) |=> $stable({c_flag, dc_flag, z_flag})); // R8

    AST_MOVLW_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_MOVLW) |=> (w_out == $past(lit_in) && $stable({c_flag, dc_flag, z_flag}))); // R9

    AST_BTST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_BTST) |=> (!wr_f && $stable(w_out))); // R10

endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .dest     (dest),
    .f_in     (f_in),
    .lit_in   (lit_in),
    .bit_sel  (bit_sel),
    .res_out  (res_out),
    .wr_f     (wr_f),
    .w_out    (w_out),
    .c_flag   (c_flag),
    .dc_flag  (dc_flag),
    .z_flag   (z_flag),
    .bit_out  (bit_out)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;

    typedef struct packed {
        logic [4:0] op;
        logic       d;
        logic [7:0] f;
        logic [7:0] lit;
        logic [2:0] idx;
        logic [7:0] wpre;
        logic       cpre;
        logic [7:0] exp;
        logic       ec;
        logic       edc;
        logic       ez;
    } vec_t;

    localparam int NVEC = 32;
    // Before each vector: C = DC = cpre, Z = 1, W = wpre.
    localparam vec_t VECS [NVEC] = '{
        '{5'd1,  1'b1, 8'h3A, 8'h00, 3'd0, 8'h46, 1'b0, 8'h80, 1'b0, 1'b1, 1'b0},
        '{5'd1,  1'b0, 8'h80, 8'h00, 3'd0, 8'h80, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1},
        '{5'd19, 1'b0, 8'h00, 8'h0F, 3'd0, 8'h01, 1'b1, 8'h10, 1'b0, 1'b1, 1'b0},
        '{5'd2,  1'b1, 8'h05, 8'h00, 3'd0, 8'h03, 1'b0, 8'h02, 1'b1, 1'b1, 1'b0},
        '{5'd2,  1'b0, 8'h03, 8'h00, 3'd0, 8'h05, 1'b1, 8'hFE, 1'b0, 1'b0, 1'b0},
        '{5'd20, 1'b0, 8'h00, 8'h10, 3'd0, 8'h01, 1'b0, 8'h0F, 1'b1, 1'b0, 1'b0},
        '{5'd20, 1'b0, 8'h00, 8'h42, 3'd0, 8'h42, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1},
        '{5'd3,  1'b1, 8'hF0, 8'h00, 3'd0, 8'h0F, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1},
        '{5'd4,  1'b0, 8'h50, 8'h00, 3'd0, 8'h05, 1'b0, 8'h55, 1'b0, 1'b0, 1'b0},
        '{5'd5,  1'b1, 8'hAA, 8'h00, 3'd0, 8'hFF, 1'b1, 8'h55, 1'b1, 1'b1, 1'b0},
        '{5'd6,  1'b0, 8'hFF, 8'h00, 3'd0, 8'h12, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
        '{5'd7,  1'b1, 8'hFF, 8'h00, 3'd0, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1},
        '{5'd8,  1'b0, 8'h00, 8'h00, 3'd0, 8'h33, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0},
        '{5'd9,  1'b1, 8'h00, 8'h00, 3'd0, 8'h77, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
        '{5'd9,  1'b0, 8'h9C, 8'h00, 3'd0, 8'h11, 1'b1, 8'h9C, 1'b1, 1'b1, 1'b0},
        '{5'd10, 1'b0, 8'h5A, 8'h00, 3'd0, 8'h21, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
        '{5'd11, 1'b1, 8'h00, 8'h00, 3'd0, 8'h21, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1},
        '{5'd12, 1'b0, 8'h13, 8'h00, 3'd0, 8'hC4, 1'b0, 8'hC4, 1'b0, 1'b0, 1'b1},
        '{5'd13, 1'b1, 8'h81, 8'h00, 3'd0, 8'h00, 1'b0, 8'h02, 1'b1, 1'b0, 1'b1},
        '{5'd13, 1'b0, 8'h40, 8'h00, 3'd0, 8'h00, 1'b1, 8'h81, 1'b0, 1'b1, 1'b1},
        '{5'd14, 1'b1, 8'h01, 8'h00, 3'd0, 8'h00, 1'b1, 8'h80, 1'b1, 1'b1, 1'b1},
        '{5'd14, 1'b0, 8'h02, 8'h00, 3'd0, 8'h00, 1'b1, 8'h81, 1'b0, 1'b1, 1'b1},
        '{5'd15, 1'b1, 8'h3C, 8'h00, 3'd0, 8'h00, 1'b0, 8'hC3, 1'b0, 1'b0, 1'b1},
        '{5'd15, 1'b0, 8'hA5, 8'h00, 3'd0, 8'h00, 1'b1, 8'h5A, 1'b1, 1'b1, 1'b1},
        '{5'd17, 1'b0, 8'h00, 8'h00, 3'd7, 8'h00, 1'b0, 8'h80, 1'b0, 1'b0, 1'b1},
        '{5'd16, 1'b0, 8'hFF, 8'h00, 3'd0, 8'h00, 1'b1, 8'hFE, 1'b1, 1'b1, 1'b1},
        '{5'd16, 1'b0, 8'hFF, 8'h00, 3'd5, 8'h00, 1'b0, 8'hDF, 1'b0, 1'b0, 1'b1},
        '{5'd21, 1'b0, 8'h00, 8'h3C, 3'd0, 8'hF0, 1'b0, 8'h30, 1'b0, 1'b0, 1'b0},
        '{5'd22, 1'b0, 8'h00, 8'h00, 3'd0, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1},
        '{5'd23, 1'b0, 8'h00, 8'h5A, 3'd0, 8'h5A, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
        '{5'd2,  1'b1, 8'h10, 8'h00, 3'd0, 8'h01, 1'b0, 8'h0F, 1'b1, 1'b0, 1'b0},
        '{5'd19, 1'b0, 8'h00, 8'hFF, 3'd0, 8'hFF, 1'b0, 8'hFE, 1'b1, 1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = 5'd0;
    logic       dest = 1'b0;
    logic [7:0] f_in = 8'h00;
    logic [7:0] lit_in = 8'h00;
    logic [2:0] bit_sel = 3'd0;
    logic [7:0] res_out, w_out;
    logic       wr_f, c_flag, dc_flag, z_flag, bit_out;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    acc_alu uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .dest(dest), .f_in(f_in), .lit_in(lit_in), .bit_sel(bit_sel),
        .res_out(res_out), .wr_f(wr_f), .w_out(w_out), .c_flag(c_flag),
        .dc_flag(dc_flag), .z_flag(z_flag), .bit_out(bit_out)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [4:0] op, input logic d, input logic [7:0] f,
                         input logic [7:0] lit, input logic [2:0] idx, input logic vld);
        @(negedge clk);
        op_code = op; dest = d; f_in = f; lit_in = lit; bit_sel = idx; op_valid = vld;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'd1, 5'd19:                          return "R3";
            5'd2, 5'd20:                          return "R4";
            5'd7, 5'd8:                           return "R6";
            5'd13, 5'd14:                         return "R7";
            5'd15:                                return "R8";
            5'd12:                                return "R9";
            5'd16, 5'd17:                         return "R10";
            default:                              return "R5";
        endcase
    endfunction

    function automatic bit goes_to_f(input logic [4:0] op, input logic d);
        if (op == 5'd10 || op == 5'd12 || op == 5'd16 || op == 5'd17) return 1'b1;
        if ((op >= 5'd1 && op <= 5'd9) || (op >= 5'd13 && op <= 5'd15)) return d;
        return 1'b0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "w_out", w_out, 8'h00);
        check("R11", "res_out", res_out, 8'h00);
        check("R11", "flags/wr/bit", {3'b0, wr_f, c_flag, dc_flag, z_flag, bit_out}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            vec_t v = VECS[i];
            string rq = req_of(v.op);
            do_op(5'd24, 1'b0, 8'h00, v.cpre ? 8'hFF : 8'h00, 3'd0, 1'b1);
            do_op(5'd19, 1'b0, 8'h00, v.cpre ? 8'h01 : 8'h00, 3'd0, 1'b1);
            do_op(5'd24, 1'b0, 8'h00, v.wpre, 3'd0, 1'b1);
            do_op(v.op, v.d, v.f, v.lit, v.idx, 1'b1);
            if (goes_to_f(v.op, v.d)) begin
                check("R2", "wr_f", {7'b0, wr_f}, 8'h01);
                check(rq, "res_out", res_out, v.exp);
                check("R2", "w_out kept", w_out, v.wpre);
            end else begin
                check("R2", "wr_f", {7'b0, wr_f}, 8'h00);
                check(rq, "w_out", w_out, v.exp);
            end
            check(rq, "flags C DC Z", {5'b0, c_flag, dc_flag, z_flag}, {5'b0, v.ec, v.edc, v.ez});
            @(negedge clk);
            check("R2", "wr_f pulse ended", {7'b0, wr_f}, 8'h00);
        end

        // R9: MOVLW keeps a cleared Z, NOP changes nothing
        do_op(5'd24, 1'b0, 8'h00, 8'h01, 3'd0, 1'b1);
        do_op(5'd19, 1'b0, 8'h00, 8'h01, 3'd0, 1'b1);
        do_op(5'd24, 1'b0, 8'h00, 8'h00, 3'd0, 1'b1);
        check("R9", "movlw w", w_out, 8'h00);
        check("R9", "movlw flags", {5'b0, c_flag, dc_flag, z_flag}, 8'h00);
        do_op(5'd0, 1'b1, 8'hFF, 8'hFF, 3'd0, 1'b1);
        check("R9", "nop w/flags/wr", {w_out[4:0], c_flag, dc_flag, z_flag | wr_f}, 8'h00);

        // R1: an operation with op_valid low is ignored
        do_op(5'd24, 1'b0, 8'h00, 8'h5A, 3'd0, 1'b1);
        do_op(5'd11, 1'b0, 8'h00, 8'h00, 3'd0, 1'b0);
        check("R1", "w held", w_out, 8'h5A);
        check("R1", "flags held", {5'b0, c_flag, dc_flag, z_flag}, 8'h00);
        do_op(5'd10, 1'b0, 8'h77, 8'h00, 3'd0, 1'b0);
        check("R1", "no write strobe", {7'b0, wr_f}, 8'h00);

        // R10: bit test
        do_op(5'd18, 1'b1, 8'h08, 8'h00, 3'd3, 1'b1);
        check("R10", "btst set bit", {7'b0, bit_out}, 8'h01);
        check("R10", "btst no write", {7'b0, wr_f}, 8'h00);
        check("R10", "btst w kept", w_out, 8'h5A);
        do_op(5'd18, 1'b1, 8'h08, 8'h00, 3'd2, 1'b1);
        check("R10", "btst clear bit", {7'b0, bit_out}, 8'h00);

        // R11: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", "w after reset", w_out, 8'h00);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule